// File: doc/BRIEF.md
# Circular DMA Channel Engine

A single data-movement channel. Each item is fetched from a source address and stored to a destination address over a simple single-beat bus master port. Either side may be a peripheral data register, with its increment left off, or a memory buffer, with its increment on. Software programs two base addresses, an item count, an item width (byte, half-word or word) and a normal or circular mode through a small word-indexed register port. It then sets the enable bit. Each time the peripheral raises its request line while the channel is idle, exactly one item moves. The channel acknowledges that item with a one-cycle pulse.

A remaining-items register counts down as items complete. At the midpoint of a pass a half-pass flag sets, and at the end of the pass a pass-complete flag sets. In circular mode the pointers return to the bases, the counter reloads and the channel keeps running, so software can drain one half while the other fills. Nothing flags a consumer that falls behind; the buffer is simply overwritten. In normal mode the channel clears its own enable at the end of the pass. A base address that is not aligned to the item width stops the channel with an error flag before any bus traffic.

Top module: `dmac_channel`

## Requirements
- R1: After reset every register reads zero and no bus request is raised.
- R2: The address of item k of the current pass is the base plus k times the item size in bytes when that side's increment is on, and the base itself when it is off; k restarts at 0 on every enable and on every circular wrap.
- R3: Width code (control bits 3:2) 0 is byte, 1 is half-word, 2 is word, and 3 behaves as word. `bus_size` carries the effective code (0, 1 or 2). The written data equals the fetched data masked to its low 1, 2 or 4 bytes.
- R4: The remaining register (index 4) reads the programmed size (index 3) minus the items completed in the current pass, falling by exactly one per item.
- R5: The half-pass flag (flags register index 5, bit 0) sets when the items completed in a pass reach size/2 rounded down, for sizes of 2 or more.
- R6: The pass-complete flag (flags bit 1) sets when the items completed in a pass reach the size.
- R7: In circular mode (control bit 1 set), completing a pass reloads the remaining register to the size, keeps the enable bit (control bit 0) set, and restarts addressing at the bases.
- R8: In normal mode, completing a pass clears the enable bit and leaves the remaining register at 0; no further bus request follows, even with the peripheral request held high.
- R9: When enabled with a half-word base whose bit 0 is set, or a word base whose bits 1:0 are not zero, the error flag (flags bit 2) sets, the enable bit clears and no bus request is raised; no request ever carries a misaligned address.
- R10: Writing 1 to a flags bit clears it and writing 0 leaves it. Flags stay set across further passes, and no extra flag appears when software does not clear them.
- R11: While enabled, writes to the source base (index 1), destination base (index 2) and size are ignored, and a control write changes only the enable bit.
- R12: Each item is a read beat at the source followed by a write beat at the destination. A beat's request, address and direction hold until granted. `periph_ack` pulses in exactly the cycle the write beat is granted.
- R13: Enabling with a size of 0 clears the enable bit at once with no bus traffic and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| periph_req | input | 1 | Peripheral asks for one item |
| periph_ack | output | 1 | One-cycle pulse when an item completes |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat direction: 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address of the beat |
| bus_size | output | 2 | Effective width code of the beat |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_gnt | input | 1 | Beat completes at this clock edge |
| bus_rdata | input | 32 | Read data, valid with bus_gnt |

## Verification
The bound checker watches several behaviours on every cycle. A requested beat must hold its address until granted. Half-word and word beats must be aligned. While enabled, the remaining count stays between one and the size. The last item of a pass must either stop the channel with a count of zero or reload the count with the channel still enabled, depending on the mode. The half-pass flag may rise only on an item completion. The bench's scenarios are needed for behaviour that spans a whole run: the exact address sequence across wraps, the data masking for each width, the sticky and write-one-to-clear behaviour of the flags, the ignoring of writes while enabled, and the absence of any transfer after a normal-mode finish, an alignment fault or a zero size.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DATA_W = 32;
    localparam int REG_AW = 3;

    // register word indices
    localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] REG_SRC   = 3'd1;
    localparam logic [REG_AW-1:0] REG_DST   = 3'd2;
    localparam logic [REG_AW-1:0] REG_SIZE  = 3'd3;
    localparam logic [REG_AW-1:0] REG_LEFT  = 3'd4;
    localparam logic [REG_AW-1:0] REG_FLAGS = 3'd5;

    // control bit positions
    localparam int CTRL_EN   = 0;
    localparam int CTRL_CIRC = 1;
    localparam int CTRL_WLO  = 2;
    localparam int CTRL_SINC = 4;
    localparam int CTRL_DINC = 5;

    // flag bit positions
    localparam int FLAG_HALF = 0;
    localparam int FLAG_DONE = 1;
    localparam int FLAG_ERR  = 2;
    localparam int FLAG_N    = 3;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       circ;
        logic [1:0] wcode;
        logic       src_inc;
        logic       dst_inc;
    } chan_cfg_t;

    typedef struct packed {
        logic stop;
        logic half;
        logic done;
        logic err;
    } seq_event_t;

    function automatic width_e width_of(logic [1:0] code);
        case (code)
            2'd0:    return W_BYTE;
            2'd1:    return W_HALF;
            default: return W_WORD;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(width_e w);
        case (w)
            W_BYTE:  return 32'h0000_00FF;
            W_HALF:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // low address bits that must be zero for the given width
    function automatic logic [1:0] align_bits(width_e w);
        case (w)
            W_BYTE:  return 2'b00;
            W_HALF:  return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  seq_event_t        ev,
    input  logic [CNT_W-1:0]  remain,
    output logic              en,
    output logic              start,
    output chan_cfg_t         cfg,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [CNT_W-1:0]  size,
    output logic [FLAG_N-1:0] flags
);

    logic wr_ctrl, wr_src, wr_dst, wr_size, wr_flags;
    logic [FLAG_N-1:0] flag_set, flag_clr;

    assign wr_ctrl  = reg_we && (reg_addr == REG_CTRL);
    assign wr_src   = reg_we && (reg_addr == REG_SRC);
    assign wr_dst   = reg_we && (reg_addr == REG_DST);
    assign wr_size  = reg_we && (reg_addr == REG_SIZE);
    assign wr_flags = reg_we && (reg_addr == REG_FLAGS);

    assign start = wr_ctrl && !en && reg_wdata[CTRL_EN];

    always_comb begin
        flag_set = '0;
        flag_set[FLAG_HALF] = ev.half;
        flag_set[FLAG_DONE] = ev.done;
        flag_set[FLAG_ERR]  = ev.err;
        flag_clr = wr_flags ? reg_wdata[FLAG_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            cfg      <= '0;
            src_base <= '0;
            dst_base <= '0;
            size     <= '0;
            flags    <= '0;
        end else begin
            // a hardware stop outranks a software write of the enable bit
            if (ev.stop)
                en <= 1'b0;
            else if (wr_ctrl)
                en <= reg_wdata[CTRL_EN];

            if (!en) begin
                if (wr_ctrl) begin
                    cfg.circ    <= reg_wdata[CTRL_CIRC];
                    cfg.wcode   <= reg_wdata[CTRL_WLO +: 2];
                    cfg.src_inc <= reg_wdata[CTRL_SINC];
                    cfg.dst_inc <= reg_wdata[CTRL_DINC];
                end
                if (wr_src)  src_base <= reg_wdata[ADDR_W-1:0];
                if (wr_dst)  dst_base <= reg_wdata[ADDR_W-1:0];
                if (wr_size) size     <= reg_wdata[CNT_W-1:0];
            end

            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_EN]       = en;
                reg_rdata[CTRL_CIRC]     = cfg.circ;
                reg_rdata[CTRL_WLO +: 2] = cfg.wcode;
                reg_rdata[CTRL_SINC]     = cfg.src_inc;
                reg_rdata[CTRL_DINC]     = cfg.dst_inc;
            end
            REG_SRC:   reg_rdata = DATA_W'(src_base);
            REG_DST:   reg_rdata = DATA_W'(dst_base);
            REG_SIZE:  reg_rdata = DATA_W'(size);
            REG_LEFT:  reg_rdata = DATA_W'(remain);
            REG_FLAGS: reg_rdata = DATA_W'(flags);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  chan_cfg_t         cfg,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  idx,
    output width_e            width,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              aligned
);

    logic [ADDR_W-1:0] offset;
    logic [1:0]        low_or;

    assign width    = width_of(cfg.wcode);
    assign offset   = ADDR_W'(idx) << width;
    assign src_addr = cfg.src_inc ? src_base + offset : src_base;
    assign dst_addr = cfg.dst_inc ? dst_base + offset : dst_base;
    assign low_or   = src_addr[1:0] | dst_addr[1:0];
    assign aligned  = (low_or & align_bits(width)) == 2'b00;

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic              circ,
    input  width_e            width,
    input  logic [CNT_W-1:0]  size,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              aligned,
    input  logic              periph_req,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              periph_ack,
    output logic [CNT_W-1:0]  idx,
    output logic [CNT_W-1:0]  remain,
    output seq_event_t        ev
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    seq_state_e        state;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  idx_next;
    logic              item_done, pass_end, half_hit;

    assign idx_next  = idx + ONE;
    assign item_done = en && (state == ST_WRITE) && bus_gnt;
    assign pass_end  = (idx_next == size);
    assign half_hit  = (size >= TWO) && (idx_next == (size >> 1));

    always_comb begin
        ev = '0;
        if (en && state == ST_IDLE) begin
            if (size == '0) begin
                ev.stop = 1'b1;
            end else if (!aligned) begin
                ev.err  = 1'b1;
                ev.stop = 1'b1;
            end
        end
        if (item_done) begin
            ev.half = half_hit;
            ev.done = pass_end;
            ev.stop = pass_end && !circ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            data_q <= '0;
        end else if (start) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else if (!en) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (size != '0 && aligned && periph_req)
                        state <= ST_READ;
                end
                ST_READ: begin
                    if (bus_gnt) begin
                        data_q <= bus_rdata & lane_mask(width);
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (bus_gnt) begin
                        state <= ST_IDLE;
                        idx   <= (pass_end && circ) ? '0 : idx_next;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_req    = en && (state != ST_IDLE);
    assign bus_we     = (state == ST_WRITE);
    assign bus_addr   = (state == ST_WRITE) ? dst_addr : src_addr;
    assign bus_size   = width;
    assign bus_wdata  = data_q;
    assign periph_ack = item_done;
    assign remain     = size - idx;

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic              bus_gnt,
    input  logic [31:0]       bus_rdata
);

    logic              en, start, aligned;
    chan_cfg_t         cfg;
    logic [ADDR_W-1:0] src_base, dst_base, src_addr, dst_addr;
    logic [CNT_W-1:0]  size, idx, remain;
    logic [FLAG_N-1:0] flags;
    width_e            width;
    seq_event_t        ev;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev        (ev),
        .remain    (remain),
        .en        (en),
        .start     (start),
        .cfg       (cfg),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .size      (size),
        .flags     (flags)
    );

    dmac_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .cfg      (cfg),
        .src_base (src_base),
        .dst_base (dst_base),
        .idx      (idx),
        .width    (width),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .aligned  (aligned)
    );

    dmac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .start      (start),
        .circ       (cfg.circ),
        .width      (width),
        .size       (size),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .aligned    (aligned),
        .periph_req (periph_req),
        .bus_gnt    (bus_gnt),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .periph_ack (periph_ack),
        .idx        (idx),
        .remain     (remain),
        .ev         (ev)
    );

endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              en,
    input logic              circ,
    input logic              item_done,
    input logic              flag_half,
    input logic [CNT_W-1:0]  remain,
    input logic [CNT_W-1:0]  size,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size
);

    // R12: a pending beat keeps its request, address and direction
    a_r12_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !reg_we) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R9: no misaligned beat reaches the bus
    a_r9_half_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size == 2'd1) |-> (bus_addr[0] == 1'b0));

    a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00));

    // R4: while running, the remaining count stays within 1..size
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        (en && size != '0) |-> (remain != '0 && remain <= size));

    // R8: last item of a normal pass stops the channel at zero
    a_r8_normal_stop: assert property (@(posedge clk) disable iff (rst)
        (item_done && !circ && remain == CNT_W'(1)) |=> (!en && remain == '0));

    // R7: last item of a circular pass reloads and keeps running
    a_r7_circ_reload: assert property (@(posedge clk) disable iff (rst)
        (item_done && circ && remain == CNT_W'(1) && !reg_we) |=> (en && remain == size));

    // R5: the half-pass flag only rises after a completed item
    a_r5_half_on_item: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_half) |-> $past(item_done));

endmodule

bind dmac_channel dmac_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .en        (en),
    .circ      (cfg.circ),
    .item_done (periph_ack),
    .flag_half (flags[0]),
    .remain    (remain),
    .size      (size),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size)
);

// File: tb/dmac_channel_tb.sv
module dmac_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        periph_req, periph_ack;
    logic        bus_req, bus_we, bus_gnt;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit finished = 0;

    // monitor model state (set by the test, advanced by the monitor)
    logic [31:0] m_src, m_dst, m_data;
    int          m_w, m_size, m_idx;
    bit          m_si, m_di, m_phase;
    int          budget = 0;
    int          items  = 0;
    int          beats  = 0;
    bit          prev_pend;
    logic [31:0] prev_addr;

    always #10 clk = ~clk;

    dmac_channel u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0] ^ 16'hC35A, ~a[15:0]};
    endfunction

    function automatic logic [31:0] wmask(int w);
        return (w == 0) ? 32'h0000_00FF : (w == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_addr(logic [31:0] base, bit inc, int w, int k);
        return inc ? base + (32'(k) << w) : base;
    endfunction

    function automatic logic [31:0] ctrl_val(bit e, bit c, int wc, bit si, bit di);
        return 32'(e) | (32'(c) << 1) | (32'(wc) << 2) | (32'(si) << 4) | (32'(di) << 5);
    endfunction

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_ch(logic [31:0] s, logic [31:0] d, int sz, int wc, bit si, bit di, bit c);
        wr(3'd1, s); wr(3'd2, d); wr(3'd3, 32'(sz));
        m_src = s; m_dst = d; m_size = sz; m_w = (wc > 2) ? 2 : wc;
        m_si = si; m_di = di; m_idx = 0; m_phase = 0;
        wr(3'd0, ctrl_val(1'b1, c, wc, si, di));
    endtask

    task automatic run_items(int n);
        budget = n;
        while (budget != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // bus slave, peripheral request source and beat checker
    initial begin
        bus_gnt = 0; bus_rdata = '0; periph_req = 0; prev_pend = 0; prev_addr = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                bus_gnt = 0; periph_req = 0; prev_pend = 0;
            end else begin
                bit g;
                if (prev_pend)
                    chk(bus_req && bus_addr == prev_addr, "R12 request held until grant", bus_addr, prev_addr);
                g = bus_req && ($urandom_range(0, 3) != 0);
                bus_gnt = g;
                bus_rdata = pat(bus_addr);
                if (bus_req) begin
                    beats++;
                    if (!m_phase) begin
                        chk(!bus_we, "R12 read beat first", 32'(bus_we), 0);
                        chk(bus_addr == exp_addr(m_src, m_si, m_w, m_idx), "R2 source address",
                            bus_addr, exp_addr(m_src, m_si, m_w, m_idx));
                        chk(bus_size == 2'(m_w), "R3 beat size", 32'(bus_size), 32'(m_w));
                        if (g) begin
                            m_data = pat(bus_addr) & wmask(m_w);
                            m_phase = 1;
                        end
                    end else begin
                        chk(bus_we, "R12 write beat second", 32'(bus_we), 1);
                        chk(bus_addr == exp_addr(m_dst, m_di, m_w, m_idx), "R2 destination address",
                            bus_addr, exp_addr(m_dst, m_di, m_w, m_idx));
                        chk(bus_wdata == m_data, "R3 masked write data", bus_wdata, m_data);
                        if (g) begin
                            m_phase = 0;
                            m_idx++;
                            if (m_idx == m_size) m_idx = 0;
                            items++;
                            if (budget > 0) budget--;
                        end
                    end
                    #1 chk(periph_ack == (bus_we && g), "R12 ack on granted write", 32'(periph_ack), 32'(bus_we && g));
                end
                prev_pend = bus_req && !g;
                prev_addr = bus_addr;
                periph_req = (budget > 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        int b0;
        void'($urandom(32'd20240611));
        rst = 1; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        m_src = '0; m_dst = '0; m_data = '0; m_w = 0; m_size = 1; m_idx = 0;
        m_si = 0; m_di = 0; m_phase = 0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 register zero after reset", v, 0);
        end
        chk(!bus_req, "R1 no request after reset", 32'(bus_req), 0);

        // word, normal, size 6: half at 3, complete at 6
        start_ch(32'h0000_1000, 32'h0000_2000, 6, 2, 1, 1, 0);
        run_items(2);
        rd(3'd4, v); chk(v == 4, "R4 remaining after 2 items", v, 4);
        rd(3'd5, v); chk(v == 0, "R5 no half flag before midpoint", v, 0);
        run_items(1);
        rd(3'd5, v); chk(v == 1, "R5 half flag at midpoint", v, 1);
        wr(3'd1, 32'h0000_7770);
        rd(3'd1, v); chk(v == 32'h0000_1000, "R11 source write ignored while enabled", v, 32'h1000);
        wr(3'd3, 32'd99);
        rd(3'd3, v); chk(v == 6, "R11 size write ignored while enabled", v, 6);
        wr(3'd0, ctrl_val(1, 1, 0, 0, 0));
        rd(3'd0, v); chk(v == ctrl_val(1, 0, 2, 1, 1), "R11 control fields kept while enabled", v, ctrl_val(1, 0, 2, 1, 1));
        run_items(3);
        rd(3'd5, v); chk(v == 3, "R6 complete flag at end of pass", v, 3);
        rd(3'd0, v); chk(v[0] == 0, "R8 enable cleared in normal mode", v, 0);
        rd(3'd4, v); chk(v == 0, "R8 remaining zero after normal pass", v, 0);
        b0 = beats;
        budget = 2; idle(20);
        chk(beats == b0, "R8 no transfer after normal finish", 32'(beats), 32'(b0));
        budget = 0; idle(2);

        // R10 write-one-to-clear
        wr(3'd5, 32'h1);
        rd(3'd5, v); chk(v == 2, "R10 clear half only", v, 2);
        wr(3'd5, 32'h0);
        rd(3'd5, v); chk(v == 2, "R10 zero write keeps flag", v, 2);
        wr(3'd5, 32'h2);
        rd(3'd5, v); chk(v == 0, "R10 clear complete", v, 0);

        // R7 circular byte, fixed source, 12 items over size 5
        start_ch(32'h0000_3003, 32'h0000_4001, 5, 0, 0, 1, 1);
        run_items(12);
        rd(3'd4, v); chk(v == 3, "R7 remaining reloads across wraps", v, 3);
        rd(3'd0, v); chk(v[0] == 1, "R7 enable kept in circular mode", v, 1);
        rd(3'd5, v); chk(v == 3, "R10 no extra flag when not cleared", v, 3);
        wr(3'd0, 32'h0); wr(3'd5, 32'h7);

        // R9 misaligned half-word source
        b0 = beats;
        start_ch(32'h0000_5001, 32'h0000_6000, 4, 1, 1, 1, 0);
        budget = 1; idle(6); budget = 0; idle(2);
        rd(3'd5, v); chk(v == 4, "R9 error flag on misaligned half", v, 4);
        rd(3'd0, v); chk(v[0] == 0, "R9 enable cleared by fault", v, 0);
        chk(beats == b0, "R9 no bus beat on fault", 32'(beats), 32'(b0));
        wr(3'd5, 32'h7);
        // word destination off by two
        start_ch(32'h0000_5000, 32'h0000_6002, 4, 2, 1, 1, 1);
        idle(4);
        rd(3'd5, v); chk(v == 4, "R9 error flag on misaligned word", v, 4);
        chk(beats == b0, "R9 no bus beat on word fault", 32'(beats), 32'(b0));
        wr(3'd5, 32'h7);

        // R13 zero size
        start_ch(32'h0000_5000, 32'h0000_6000, 0, 0, 1, 1, 1);
        budget = 1; idle(6); budget = 0; idle(2);
        rd(3'd0, v); chk(v[0] == 0, "R13 zero size clears enable", v, 0);
        rd(3'd5, v); chk(v == 0, "R13 zero size raises no flag", v, 0);
        chk(beats == b0, "R13 zero size moves nothing", 32'(beats), 32'(b0));

        // R3 width code 3 acts as word
        start_ch(32'h0000_8000, 32'h0000_9000, 3, 3, 1, 0, 0);
        run_items(3);
        rd(3'd5, v); chk(v == 3, "R3 code three runs a full word pass", v, 3);
        wr(3'd5, 32'h7);

        // random configurations
        for (int t = 0; t < 24; t++) begin
            int wc, sz, n, exph, expd;
            bit c, si, di;
            logic [31:0] s, d;
            wc = $urandom_range(0, 3);
            sz = $urandom_range(1, 12);
            c  = $urandom_range(0, 1);
            si = $urandom_range(0, 1);
            di = $urandom_range(0, 1);
            s  = $urandom & 32'h0000_FFF0;
            d  = $urandom & 32'h0000_FFF0;
            n  = c ? $urandom_range(1, 3 * sz) : sz;
            start_ch(s, d, sz, wc, si, di, c);
            run_items(n);
            rd(3'd4, v);
            chk(v == 32'(c ? sz - (n % sz) : 0), "R4 remaining after random run", v, 32'(c ? sz - (n % sz) : 0));
            exph = (sz >= 2 && n >= sz / 2) ? 1 : 0;
            expd = (n >= sz) ? 1 : 0;
            rd(3'd5, v);
            chk(v == 32'(exph | (expd << 1)), "R5 R6 flags after random run", v, 32'(exph | (expd << 1)));
            rd(3'd0, v);
            chk(v[0] == c, "R7 R8 enable after random run", 32'(v[0]), 32'(c));
            wr(3'd0, 32'h0);
            wr(3'd5, 32'h7);
        end

        idle(4);
        report();
    end

endmodule